// File: doc/BRIEF.md
# Dual-Port Collision RAM

This block is a shared memory of 2048 bytes (sized by parameters) with two independent access ports, called left and right. Each port has its own active-low select, a write strobe (low means write), an active-low output gate, an address and write and read data. Both ports can work on different locations in the same cycle, and both can read one location together. The design is a clocked model of an asynchronous part: writes land at the clock edge and read data is registered.

When both ports are selected on the same address, an arbiter gives the location to the port that got there first. An earlier arrival means a select and address already present in the previous cycle. The other port sees its active-low busy flag, its writes are dropped, and while the owner writes the shared word its read register holds the old value. A second instance built as a slave takes the master's busy flags as inputs, so two instances can sit side by side to form a wider word.

Top module: `dual_port_collision_ram`

## Requirements
- R1: A port writes when its select and write strobe are both low at a clock edge. A read (select low, strobe high) loads the addressed word into the port's read register at the edge, and the word shows one cycle later. Both ports reading one address in the same cycle get the same word.
- R2: In master mode, a busy output is low only while both selects are low and both addresses are equal. At most one busy output is low at a time.
- R3: The port whose select and address were already present in the previous cycle wins the match. The winner keeps the location as long as the match lasts.
- R4: If both ports start a match in the same cycle, the left port wins and the right busy goes low.
- R5: A busy output returns high in the same cycle that the addresses differ or either select goes high.
- R6: A busy port's write is dropped. In master mode the busy inputs act as an extra write inhibit and must be tied high when unused. In slave mode a low busy input blocks that port's writes and both busy outputs stay high.
- R7: A port that is busy while the owner writes the shared word keeps its read register frozen. The register updates again once busy goes high or the port flips its write strobe.
- R8: A port's read data output is zero while its output gate or select is high. Otherwise it shows the port's read register.
- R9: Reset clears the owner, the arrival history and both read registers, so the first match after reset is judged as a tie. Memory contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| l_ce_ni | input | 1 | left select, active low |
| l_we_ni | input | 1 | left write strobe, low = write |
| l_oe_ni | input | 1 | left output gate, active low |
| l_addr_i | input | 11 | left address |
| l_wdata_i | input | 8 | left write data |
| l_busy_ni | input | 1 | left busy input (slave) / extra write inhibit (master) |
| l_rdata_o | output | 8 | left read data |
| l_busy_no | output | 1 | left busy flag, active low |
| r_ce_ni | input | 1 | right select, active low |
| r_we_ni | input | 1 | right write strobe, low = write |
| r_oe_ni | input | 1 | right output gate, active low |
| r_addr_i | input | 11 | right address |
| r_wdata_i | input | 8 | right write data |
| r_busy_ni | input | 1 | right busy input (slave) / extra write inhibit (master) |
| r_rdata_o | output | 8 | right read data |
| r_busy_no | output | 1 | right busy flag, active low |

## Verification
The functions that share a cycle are the owner's write to the shared word and the loser's read of it. The loser must keep its old word instead of taking the new one or the stale memory value. Random traffic over a pool of six addresses, including both ends of the range, makes both ports meet, tie and write over each other often. Directed sequences set up left-first, right-first and same-cycle arrivals and then release them. A bench model built from the requirements judges every cycle: it predicts busy from arrival order, applies only the writes that are allowed, and tracks the freeze of each read register.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } own_e;
endpackage

// File: rtl/dpr_mem.sv
module dpr_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          l_wr_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_word_o,
  input  logic          r_wr_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_word_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (l_wr_i) mem_q[l_addr_i] <= l_wdata_i;
    if (r_wr_i) mem_q[r_addr_i] <= r_wdata_i;
  end

  assign l_word_o = mem_q[l_addr_i];
  assign r_word_o = mem_q[r_addr_i];
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_act_i,
  input  logic          r_act_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [AW-1:0] r_addr_i,
  output logic          l_busy_o,
  output logic          r_busy_o
);
  own_e          owner_q, win;
  logic          l_pact_q, r_pact_q;
  logic [AW-1:0] l_paddr_q, r_paddr_q;
  logic          match, l_held, r_held;

  always_comb begin
    match  = l_act_i && r_act_i && (l_addr_i == r_addr_i);
    l_held = l_pact_q && l_act_i && (l_paddr_q == l_addr_i);
    r_held = r_pact_q && r_act_i && (r_paddr_q == r_addr_i);
    win    = owner_q;
    // new match: earlier arrival wins, same-cycle tie goes left
    if (owner_q == OWN_NONE) win = (r_held && !l_held) ? OWN_R : OWN_L;
    l_busy_o = match && (win == OWN_R);
    r_busy_o = match && (win == OWN_L);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= OWN_NONE;
      l_pact_q  <= 1'b0;
      r_pact_q  <= 1'b0;
      l_paddr_q <= '0;
      r_paddr_q <= '0;
    end else begin
      owner_q   <= match ? win : OWN_NONE;
      l_pact_q  <= l_act_i;
      r_pact_q  <= r_act_i;
      l_paddr_q <= l_addr_i;
      r_paddr_q <= r_addr_i;
    end
  end

  // R2
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_busy_o && r_busy_o));
  // R5
  busy_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_act_i || !r_act_i || (l_addr_i != r_addr_i)) |-> (!l_busy_o && !r_busy_o));
  // R3
  owner_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_o && l_act_i && r_act_i && $stable(l_addr_i) && $stable(r_addr_i))
      |=> (!(l_act_i && r_act_i && l_addr_i == r_addr_i) || l_busy_o));
endmodule

// File: rtl/dpr_read_port.sv
module dpr_read_port #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          we_ni,
  input  logic          busy_i,
  input  logic          peer_wr_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] rd_o
);
  logic          frz_q, pwe_q, frz_d, upd;
  logic [DW-1:0] rd_q;

  always_comb begin
    // hold while busy and owner has written, unless strobe flipped
    frz_d = busy_i && (pwe_q == we_ni) && (frz_q || peer_wr_i);
    upd   = act_i && we_ni && !frz_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= 1'b0;
      pwe_q <= 1'b1;
      rd_q  <= '0;
    end else begin
      frz_q <= frz_d;
      pwe_q <= we_ni;
      if (upd) rd_q <= word_i;
    end
  end

  assign rd_o = rd_q;

  // R7
  frz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && peer_wr_i && pwe_q == we_ni) |=> $stable(rd_q));
endmodule

// File: rtl/dual_port_collision_ram.sv
module dual_port_collision_ram #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_ce_ni,
  input  logic          l_we_ni,
  input  logic          l_oe_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  input  logic          l_busy_ni,
  output logic [DW-1:0] l_rdata_o,
  output logic          l_busy_no,
  input  logic          r_ce_ni,
  input  logic          r_we_ni,
  input  logic          r_oe_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  input  logic          r_busy_ni,
  output logic [DW-1:0] r_rdata_o,
  output logic          r_busy_no
);
  logic          l_act, r_act, l_busy, r_busy, l_wr, r_wr;
  logic [DW-1:0] l_word, r_word, l_rd, r_rd;

  assign l_act = !l_ce_ni;
  assign r_act = !r_ce_ni;

  generate
    if (IS_MASTER) begin : g_master
      logic l_arb, r_arb;
      dpr_arbiter #(.AW(AW)) u_arb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .l_act_i (l_act),
        .r_act_i (r_act),
        .l_addr_i(l_addr_i),
        .r_addr_i(r_addr_i),
        .l_busy_o(l_arb),
        .r_busy_o(r_arb)
      );
      assign l_busy    = l_arb || !l_busy_ni;
      assign r_busy    = r_arb || !r_busy_ni;
      assign l_busy_no = !l_arb;
      assign r_busy_no = !r_arb;
    end else begin : g_slave
      assign l_busy    = !l_busy_ni;
      assign r_busy    = !r_busy_ni;
      assign l_busy_no = 1'b1;
      assign r_busy_no = 1'b1;
    end
  endgenerate

  assign l_wr = l_act && !l_we_ni && !l_busy;
  assign r_wr = r_act && !r_we_ni && !r_busy;

  dpr_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i    (clk_i),
    .l_wr_i   (l_wr),
    .l_addr_i (l_addr_i),
    .l_wdata_i(l_wdata_i),
    .l_word_o (l_word),
    .r_wr_i   (r_wr),
    .r_addr_i (r_addr_i),
    .r_wdata_i(r_wdata_i),
    .r_word_o (r_word)
  );

  dpr_read_port #(.DW(DW)) u_lrd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (l_act),
    .we_ni    (l_we_ni),
    .busy_i   (l_busy),
    .peer_wr_i(r_wr),
    .word_i   (l_word),
    .rd_o     (l_rd)
  );

  dpr_read_port #(.DW(DW)) u_rrd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (r_act),
    .we_ni    (r_we_ni),
    .busy_i   (r_busy),
    .peer_wr_i(l_wr),
    .word_i   (r_word),
    .rd_o     (r_rd)
  );

  assign l_rdata_o = (l_act && !l_oe_ni) ? l_rd : '0;
  assign r_rdata_o = (r_act && !r_oe_ni) ? r_rd : '0;

  // R6
  no_lose_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_no || !l_busy_ni) |-> !l_wr);
  // R6
  no_lose_wr_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_busy_no || !r_busy_ni) |-> !r_wr);
  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_oe_ni || l_ce_ni) |-> (l_rdata_o == '0));
  // R2
  busy_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_no || !r_busy_no) |-> (!l_ce_ni && !r_ce_ni && l_addr_i == r_addr_i));
endmodule

// File: tb/dual_port_collision_ram_tb.sv
module dual_port_collision_ram_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic lce = 1, lwe = 1, loe = 1, rce = 1, rwe = 1, roe = 1;
  logic [10:0] la = '0, ra = '0;
  logic [7:0]  ld = '0, rd = '0;
  logic [7:0]  lq, rq;
  logic        lb, rb;

  logic sce = 1, swe = 1, soe = 1, slbi = 1, srbi = 1;
  logic [10:0] sa = '0;
  logic [7:0]  sd = '0, slq, srq;
  logic        slb, srb;

  int total = 0, bad = 0;

  dual_port_collision_ram u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(lce), .l_we_ni(lwe), .l_oe_ni(loe), .l_addr_i(la), .l_wdata_i(ld),
    .l_busy_ni(1'b1), .l_rdata_o(lq), .l_busy_no(lb),
    .r_ce_ni(rce), .r_we_ni(rwe), .r_oe_ni(roe), .r_addr_i(ra), .r_wdata_i(rd),
    .r_busy_ni(1'b1), .r_rdata_o(rq), .r_busy_no(rb)
  );

  dual_port_collision_ram #(.IS_MASTER(1'b0)) u_slv (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_ni(sce), .l_we_ni(swe), .l_oe_ni(soe), .l_addr_i(sa), .l_wdata_i(sd),
    .l_busy_ni(slbi), .l_rdata_o(slq), .l_busy_no(slb),
    .r_ce_ni(1'b1), .r_we_ni(1'b1), .r_oe_ni(1'b1), .r_addr_i(11'd0), .r_wdata_i(8'd0),
    .r_busy_ni(srbi), .r_rdata_o(srq), .r_busy_no(srb)
  );

  // reference model state
  logic [7:0]  mm [2048];
  int          own = 0;
  bit          plact = 0, pract = 0, plwe = 1, prwe = 1, lfz = 0, rfz = 0;
  logic [10:0] pladdr = '0, praddr = '0;
  logic [7:0]  lrd = '0, rrd = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] pick_addr(input int k);
    case (k % 6)
      0: return 11'd0;
      1: return 11'd1;
      2: return 11'd2;
      3: return 11'd3;
      4: return 11'd2046;
      default: return 11'd2047;
    endcase
  endfunction

  // one cycle: drive, check against model, advance model across the edge
  task automatic step(input bit a_ce, a_we, a_oe, input logic [10:0] a_ad, input logic [7:0] a_d,
                      input bit b_ce, b_we, b_oe, input logic [10:0] b_ad, input logic [7:0] b_d);
    bit l_on, r_on, match, lh, rh, bl, br, lw, rw, lhold, rhold;
    int win;
    lce = a_ce; lwe = a_we; loe = a_oe; la = a_ad; ld = a_d;
    rce = b_ce; rwe = b_we; roe = b_oe; ra = b_ad; rd = b_d;
    #1;
    l_on  = !a_ce;
    r_on  = !b_ce;
    match = l_on && r_on && (a_ad == b_ad);
    lh    = plact && l_on && (pladdr == a_ad);
    rh    = pract && r_on && (praddr == b_ad);
    win   = (own != 0) ? own : ((rh && !lh) ? 2 : 1);
    bl    = match && (win == 2);
    br    = match && (win == 1);
    lw    = l_on && !a_we && !bl;
    rw    = r_on && !b_we && !br;
    lhold = bl && (plwe == a_we) && (lfz || rw);
    rhold = br && (prwe == b_we) && (rfz || lw);
    chk("R2/R3/R4/R5 left busy", {31'd0, lb}, {31'd0, !bl});
    chk("R2/R3/R4/R5 right busy", {31'd0, rb}, {31'd0, !br});
    chk("R1/R7/R8 left rdata", {24'd0, lq}, {24'd0, (l_on && !a_oe) ? lrd : 8'd0});
    chk("R1/R7/R8 right rdata", {24'd0, rq}, {24'd0, (r_on && !b_oe) ? rrd : 8'd0});
    if (l_on && a_we && !lhold) lrd = mm[a_ad];
    if (r_on && b_we && !rhold) rrd = mm[b_ad];
    if (lw) mm[a_ad] = a_d;   // R6: only unblocked writes land
    if (rw) mm[b_ad] = b_d;
    lfz = lhold; rfz = rhold;
    plact = l_on; pract = r_on; pladdr = a_ad; praddr = b_ad; plwe = a_we; prwe = b_we;
    own = match ? win : 0;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1, 1, 1, 11'd0, 8'd0, 1, 1, 1, 11'd0, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R9: reset state
    lce = 0; loe = 0; lwe = 1;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 left rdata in reset", {24'd0, lq}, 32'd0);
    chk("R9 left busy in reset", {31'd0, lb}, 32'd1);
    chk("R9 right busy in reset", {31'd0, rb}, 32'd1);
    lce = 1; loe = 1;
    @(negedge clk);
    rst_n = 1'b1;

    // prefill pool
    for (int i = 0; i < 6; i++) step(0, 0, 1, pick_addr(i), 8'(8'h10 + i), 1, 1, 1, 11'd0, 8'd0);
    step(1, 1, 1, 11'd0, 8'd0, 0, 0, 1, 11'd5, 8'h55);
    idle();

    // R1 R4: both read same word, tie -> left wins
    step(0, 1, 0, 11'd0, 8'd0, 0, 1, 0, 11'd0, 8'd0);
    chk("R4 tie right busy", {31'd0, rb}, 32'd0);
    step(0, 1, 0, 11'd0, 8'd0, 0, 1, 0, 11'd0, 8'd0);
    chk("R1 shared read left", {24'd0, lq}, 32'h10);
    chk("R1 shared read right", {24'd0, rq}, 32'h10);
    idle();

    // R3: right first
    step(1, 1, 1, 11'd1, 8'd0, 0, 1, 0, 11'd1, 8'd0);
    step(0, 1, 0, 11'd1, 8'd0, 0, 1, 0, 11'd1, 8'd0);
    chk("R3 right-first left busy", {31'd0, lb}, 32'd0);
    // R5: right deselects, left busy clears same cycle
    step(0, 1, 0, 11'd1, 8'd0, 1, 1, 1, 11'd1, 8'd0);
    chk("R5 release", {31'd0, lb}, 32'd1);
    idle();

    // R7: left owns 2, right reads, left writes
    step(0, 1, 0, 11'd2, 8'd0, 1, 1, 1, 11'd0, 8'd0);
    step(0, 1, 0, 11'd2, 8'd0, 0, 1, 0, 11'd2, 8'd0);
    step(0, 0, 0, 11'd2, 8'hA7, 0, 1, 0, 11'd2, 8'd0);
    step(0, 1, 0, 11'd2, 8'd0, 0, 1, 0, 11'd2, 8'd0);
    step(0, 1, 0, 11'd2, 8'd0, 0, 1, 0, 11'd2, 8'd0);
    chk("R7 frozen right", {24'd0, rq}, 32'h12);
    step(1, 1, 1, 11'd2, 8'd0, 0, 1, 0, 11'd2, 8'd0);
    step(1, 1, 1, 11'd2, 8'd0, 0, 1, 0, 11'd2, 8'd0);
    chk("R7 right updates after release", {24'd0, rq}, 32'hA7);
    idle();

    // R6: right owns 3, left write blocked
    step(1, 1, 1, 11'd0, 8'd0, 0, 1, 1, 11'd3, 8'd0);
    step(0, 0, 1, 11'd3, 8'hEE, 0, 1, 1, 11'd3, 8'd0);
    step(1, 1, 1, 11'd0, 8'd0, 1, 1, 1, 11'd0, 8'd0);
    step(0, 1, 0, 11'd3, 8'd0, 1, 1, 1, 11'd0, 8'd0);
    step(0, 1, 0, 11'd3, 8'd0, 1, 1, 1, 11'd0, 8'd0);
    chk("R6 blocked write", {24'd0, lq}, 32'h13);
    idle();

    // R4 R6: both write 2046 in one cycle, left wins
    step(0, 0, 1, 11'd2046, 8'h3C, 0, 0, 1, 11'd2046, 8'hC3);
    idle();
    step(1, 1, 1, 11'd0, 8'd0, 0, 1, 0, 11'd2046, 8'd0);
    step(1, 1, 1, 11'd0, 8'd0, 0, 1, 0, 11'd2046, 8'd0);
    chk("R4 tie write winner", {24'd0, rq}, 32'h3C);
    // R8: gate high
    step(1, 1, 1, 11'd0, 8'd0, 0, 1, 1, 11'd2046, 8'd0);
    chk("R8 gated", {24'd0, rq}, 32'd0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom;
      step(k[0] & k[1], k[2] | k[12], k[3] & k[13], pick_addr(k[7:4] % 6), 8'(k[31:24]),
           k[8] & k[9], k[10] | k[14], k[11] & k[15], pick_addr(k[19:16] % 6), 8'(k[23:16]));
    end
    idle();

    // slave mode: R6
    sce = 0; swe = 0; sa = 11'd5; sd = 8'h11;
    @(negedge clk);
    slbi = 0; sd = 8'hAA;
    @(negedge clk);
    chk("R6 slave busy out left", {31'd0, slb}, 32'd1);
    chk("R6 slave busy out right", {31'd0, srb}, 32'd1);
    slbi = 1; swe = 1; soe = 0;
    @(negedge clk);
    chk("R6 slave inhibited write", {24'd0, slq}, 32'h11);
    sce = 1; soe = 1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule